// File: doc/BRIEF.md
# Level-Masked Interrupt Priority Arbiter

This block decides which of a set of level-sensitive peripheral interrupt requests the processor takes next. Each source has its own 5-bit priority level register, written through a simple write port. Levels run from 16, the most urgent, up to 31, and 31 turns the source off. All levels reset to 31, so every source starts disabled. A request competes only when its level is numerically below the processor's current level mask. The lowest level wins. When two or more sources share that level, the lowest source number wins. The choice is made by a combinational tree and registered once per clock.

A take happens only when the global interrupt enable flag is set and the processor signals an interruptible point. That point is either an instruction boundary or a point inside a string instruction. On a take, the block pulses a one-cycle strobe and presents the winning source number and its vector index, which is a fixed base plus the source number. It also presents the status values to load: the mask becomes the accepted level and the stack-select flag becomes 0, which selects the system stack. A busy timer then covers the context save: 19 cycles when the stack pointer is word aligned, 20 when it is only halfword aligned. A return request starts a 9-cycle restore window. No take is issued while either window runs. Outside a take, the status outputs follow the mask and stack-select values supplied by the processor.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset, `take` and `busy` are 0 and every level register holds 31, so requests raised with mask 31 and enables set cause no take.
- R2: A source whose level is 31 is never taken, whatever the mask.
- R3: A request is eligible only when its level is strictly less than `ilm_in`; a level equal to `ilm_in` is not taken.
- R4: No take is issued while `ie_flag` is 0 or `at_boundary` is 0.
- R5: Among eligible requests, the one with the numerically lowest level is taken.
- R6: Among eligible requests sharing the lowest level, the lowest source number is taken.
- R7: `take` is high for exactly one cycle, in the cycle after the clock edge at which the conditions held. With it, `take_num` gives the source and `take_vec` equals VEC_BASE (default 64) plus `take_num`.
- R8: While `take` is high, `ilm_out` equals the accepted source's level and `ssel_out` is 0, even when `ssel_in` is 1.
- R9: `busy` rises together with `take` and stays high for 19 cycles when `sp_aligned4` was 1 at the take, or 20 cycles when it was 0. No take is issued while `busy` is high, so a request held through the window is taken again 20 cycles after a 19-cycle entry.
- R10: `reti_go` seen while not busy starts a 9-cycle busy window. It overrides a take in that same cycle, and no take is issued during the window.
- R11: `reti_go` seen while busy is ignored: the running window keeps its original length.
- R12: A level write is used from the clock edge after the write; a take decided at the write edge still uses the old level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | N_SRC | Level-sensitive request per source |
| lvl_we | input | 1 | Level register write enable |
| lvl_widx | input | IDX_W | Source whose level is written |
| lvl_wdata | input | 5 | Level value to write |
| ilm_in | input | 5 | Current processor level mask |
| ssel_in | input | 1 | Current stack-select flag |
| ie_flag | input | 1 | Global interrupt enable |
| at_boundary | input | 1 | Processor is at an interruptible point |
| sp_aligned4 | input | 1 | Stack pointer is word aligned |
| reti_go | input | 1 | Return-from-interrupt begins |
| take | output | 1 | One-cycle acceptance strobe |
| take_num | output | IDX_W | Accepted source number |
| take_vec | output | 8 | Vector index of the accepted source |
| ilm_out | output | 5 | Mask value to load into the status word |
| ssel_out | output | 1 | Stack-select value to load |
| busy | output | 1 | Entry or return sequence in progress |

## Verification
Two events can fall in the same cycle: a return that starts while a request is eligible, and a return request that arrives in the middle of an entry window. The bench drives `reti_go` together with an eligible, enabled request. It then checks that no strobe appears, that the 9-cycle window runs, and that the pending request is taken one idle cycle after the window closes. In the second case it pulses `reti_go` partway through a 19-cycle entry and judges by the total length of that busy window.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W = 5;
  localparam int NUM_W = 8;
  localparam logic [LVL_W-1:0] LVL_OFF = 5'd31;

  typedef struct packed {
    logic             vld;
    logic [LVL_W-1:0] lvl;
    logic [NUM_W-1:0] num;
  } cand_t;

  // A source competes when it requests, is not disabled and beats the mask.
  function automatic logic is_eligible(logic r, logic [LVL_W-1:0] lvl,
                                       logic [LVL_W-1:0] ilm);
    return r && (lvl != LVL_OFF) && (lvl < ilm);
  endfunction

  // Lower level wins; on equal level the left (lower number) side is kept.
  function automatic cand_t pick(cand_t a, cand_t b);
    if (!b.vld) return a;
    if (!a.vld) return b;
    if (b.lvl < a.lvl) return b;
    return a;
  endfunction

  function automatic logic [NUM_W-1:0] vec_of(logic [NUM_W-1:0] base,
                                               logic [NUM_W-1:0] num);
    return base + num;
  endfunction
endpackage

// File: rtl/irq_lvl_file.sv
module irq_lvl_file #(
  parameter int N_SRC = 8,
  parameter int IDX_W = 3
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  we,
  input  logic [IDX_W-1:0]                      widx,
  input  logic [irq_arb_pkg::LVL_W-1:0]         wdata,
  output logic [N_SRC*irq_arb_pkg::LVL_W-1:0]   lvl_flat
);
  import irq_arb_pkg::*;

  for (genvar i = 0; i < N_SRC; i++) begin : g_ent
    logic [LVL_W-1:0] lvl_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lvl_q <= LVL_OFF;
      else if (we && (widx == IDX_W'(i)))
        lvl_q <= wdata;
    end
    assign lvl_flat[i*LVL_W +: LVL_W] = lvl_q;
  end
endmodule

// File: rtl/irq_prio_tree.sv
module irq_prio_tree #(
  parameter int N_SRC = 8
) (
  input  logic [N_SRC-1:0]                      req,
  input  logic [N_SRC*irq_arb_pkg::LVL_W-1:0]   lvl_flat,
  input  logic [irq_arb_pkg::LVL_W-1:0]         ilm,
  output irq_arb_pkg::cand_t                    best
);
  import irq_arb_pkg::*;

  localparam int DEPTH = (N_SRC > 1) ? $clog2(N_SRC) : 0;
  localparam int NP    = 1 << DEPTH;
  localparam int NODES = 2 * NP - 1;

  cand_t node [NODES];

  // Leaves sit at NP-1+i; padding leaves never win.
  for (genvar i = 0; i < NP; i++) begin : g_leaf
    if (i < N_SRC) begin : g_real
      assign node[NP-1+i].vld = is_eligible(req[i], lvl_flat[i*LVL_W +: LVL_W], ilm);
      assign node[NP-1+i].lvl = lvl_flat[i*LVL_W +: LVL_W];
      assign node[NP-1+i].num = NUM_W'(i);
    end else begin : g_pad
      assign node[NP-1+i] = '0;
    end
  end

  for (genvar k = 0; k < NP - 1; k++) begin : g_node
    assign node[k] = pick(node[2*k+1], node[2*k+2]);
  end

  assign best = node[0];
endmodule

// File: rtl/irq_seq_timer.sv
module irq_seq_timer #(
  parameter int ENT_A = 19,
  parameter int ENT_U = 20,
  parameter int RET_C = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_entry,
  input  logic aligned,
  input  logic go_ret,
  output logic busy
);
  localparam int MAXC = (ENT_U > ENT_A) ? ((ENT_U > RET_C) ? ENT_U : RET_C)
                                        : ((ENT_A > RET_C) ? ENT_A : RET_C);
  localparam int CW = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (go_entry)
      cnt_q <= aligned ? CW'(ENT_A) : CW'(ENT_U);
    else if (go_ret)
      cnt_q <= CW'(RET_C);
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter #(
  parameter int         N_SRC    = 8,
  parameter int         IDX_W    = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  parameter logic [7:0] VEC_BASE = 8'd64,
  parameter int         ENT_A    = 19,
  parameter int         ENT_U    = 20,
  parameter int         RET_C    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_req,
  input  logic             lvl_we,
  input  logic [IDX_W-1:0] lvl_widx,
  input  logic [4:0]       lvl_wdata,
  input  logic [4:0]       ilm_in,
  input  logic             ssel_in,
  input  logic             ie_flag,
  input  logic             at_boundary,
  input  logic             sp_aligned4,
  input  logic             reti_go,
  output logic             take,
  output logic [IDX_W-1:0] take_num,
  output logic [7:0]       take_vec,
  output logic [4:0]       ilm_out,
  output logic             ssel_out,
  output logic             busy
);
  import irq_arb_pkg::*;

  logic [N_SRC*LVL_W-1:0] lvl_flat;
  cand_t                  best;
  logic                   accept_now;
  logic                   ret_fire;

  irq_lvl_file #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_lvl (
    .clk(clk), .rst_n(rst_n), .we(lvl_we), .widx(lvl_widx),
    .wdata(lvl_wdata), .lvl_flat(lvl_flat)
  );

  irq_prio_tree #(.N_SRC(N_SRC)) u_tree (
    .req(irq_req), .lvl_flat(lvl_flat), .ilm(ilm_in), .best(best)
  );

  // A return in flight outranks a new entry in the same cycle.
  assign ret_fire   = reti_go && !busy;
  assign accept_now = ie_flag && at_boundary && !busy && !reti_go && best.vld;

  irq_seq_timer #(.ENT_A(ENT_A), .ENT_U(ENT_U), .RET_C(RET_C)) u_tmr (
    .clk(clk), .rst_n(rst_n), .go_entry(accept_now), .aligned(sp_aligned4),
    .go_ret(ret_fire), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take     <= 1'b0;
      take_num <= '0;
      take_vec <= VEC_BASE;
      ilm_out  <= LVL_OFF;
      ssel_out <= 1'b0;
    end else begin
      take <= accept_now;
      if (accept_now) begin
        take_num <= best.num[IDX_W-1:0];
        take_vec <= vec_of(VEC_BASE, best.num);
        ilm_out  <= best.lvl;
        ssel_out <= 1'b0;
      end else begin
        ilm_out  <= ilm_in;
        ssel_out <= ssel_in;
      end
    end
  end
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk #(
  parameter int IDX_W = 3,
  parameter int ENT_A = 19,
  parameter int ENT_U = 20,
  parameter int RET_C = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             take,
  input logic             busy,
  input logic [4:0]       ilm_in,
  input logic [4:0]       ilm_out,
  input logic             ssel_out,
  input logic             ie_flag,
  input logic             at_boundary,
  input logic             reti_go,
  input logic             accept_now,
  input logic             ret_fire
);
  int run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 0;
    else        run_q <= busy ? run_q + 1 : 0;
  end

  // R7
  take_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);
  // R9
  take_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (busy && !$past(busy)));
  // R8
  ssel_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !ssel_out);
  // R3
  mask_strict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (ilm_out < $past(ilm_in)));
  // R4
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ($past(ie_flag) && $past(at_boundary)));
  // R10
  ret_over_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_fire |-> !accept_now);
  // R10
  ret_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reti_go) && !$past(busy)) |-> (busy && !take));
  // R9
  window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && run_q != 0) |-> (run_q == ENT_A || run_q == ENT_U || run_q == RET_C));
endmodule

bind irq_level_arbiter irq_arb_chk #(
  .IDX_W(IDX_W), .ENT_A(ENT_A), .ENT_U(ENT_U), .RET_C(RET_C)
) u_chk (
  .clk(clk), .rst_n(rst_n), .take(take), .busy(busy), .ilm_in(ilm_in),
  .ilm_out(ilm_out), .ssel_out(ssel_out), .ie_flag(ie_flag),
  .at_boundary(at_boundary), .reti_go(reti_go), .accept_now(accept_now),
  .ret_fire(ret_fire)
);

// File: tb/irq_level_arbiter_tb.sv
`timescale 1ns/1ps
module irq_level_arbiter_tb;
  localparam int N = 8;
  localparam int IW = 3;
  localparam int BASE = 64;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] irq_req = '0;
  logic lvl_we = 0;
  logic [IW-1:0] lvl_widx = '0;
  logic [4:0] lvl_wdata = '0, ilm_in = 5'd31;
  logic ssel_in = 0, ie_flag = 0, at_boundary = 0, sp_aligned4 = 1, reti_go = 0;
  logic take, ssel_out, busy;
  logic [IW-1:0] take_num;
  logic [7:0] take_vec;
  logic [4:0] ilm_out;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_level_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .lvl_we(lvl_we),
    .lvl_widx(lvl_widx), .lvl_wdata(lvl_wdata), .ilm_in(ilm_in),
    .ssel_in(ssel_in), .ie_flag(ie_flag), .at_boundary(at_boundary),
    .sp_aligned4(sp_aligned4), .reti_go(reti_go), .take(take),
    .take_num(take_num), .take_vec(take_vec), .ilm_out(ilm_out),
    .ssel_out(ssel_out), .busy(busy)
  );

  task automatic check(string rq, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_lvl(int idx, int val);
    lvl_we = 1; lvl_widx = IW'(idx); lvl_wdata = 5'(val);
    step();
    lvl_we = 0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 64) begin n++; step(); end
  endtask

  task automatic drain();
    int n;
    irq_req = '0; reti_go = 0;
    count_busy(n);
    step();
  endtask

  task automatic t_reset();
    check("R1 take", take, 0);
    check("R1 busy", busy, 0);
    irq_req = '1; ilm_in = 31; ie_flag = 1; at_boundary = 1;
    step(); step();
    check("R1 all levels 31", take, 0);
    drain();
  endtask

  task automatic t_level31();
    wr_lvl(1, 31);
    irq_req = 8'b0000_0010; ilm_in = 31;
    step(); step();
    check("R2 level 31 ignored", take, 0);
    drain();
  endtask

  task automatic t_strict();
    int n;
    wr_lvl(3, 20);
    ssel_in = 1; sp_aligned4 = 1;
    irq_req = 8'b0000_1000; ilm_in = 20;
    step();
    check("R3 equal level not taken", take, 0);
    ilm_in = 21;
    step();
    check("R3 lower level taken", take, 1);
    check("R7 take_num", take_num, 3);
    check("R7 take_vec", take_vec, BASE + 3);
    check("R8 ilm_out", ilm_out, 20);
    check("R8 ssel_out", ssel_out, 0);
    irq_req = '0;
    count_busy(n);
    check("R9 aligned entry length", n, 19);
    check("R8 ssel follows input after take", ssel_out, 1);
    ssel_in = 0; ilm_in = 31;
    step();
  endtask

  task automatic t_enable();
    wr_lvl(3, 20);
    irq_req = 8'b0000_1000; ilm_in = 31;
    ie_flag = 0; at_boundary = 1;
    step(); step();
    check("R4 ie_flag low", take, 0);
    ie_flag = 1; at_boundary = 0;
    step(); step();
    check("R4 boundary low", take, 0);
    at_boundary = 1;
    step();
    check("R4 enabled take", take, 1);
    drain();
  endtask

  task automatic t_prio();
    int n;
    wr_lvl(1, 25); wr_lvl(5, 18); wr_lvl(6, 22); wr_lvl(3, 31);
    sp_aligned4 = 0;
    irq_req = 8'b0110_0010; ilm_in = 31;
    step();
    check("R5 lowest level num", take_num, 5);
    check("R5 ilm_out", ilm_out, 18);
    irq_req = '0;
    count_busy(n);
    check("R9 unaligned entry length", n, 20);
    sp_aligned4 = 1;
    step();
  endtask

  task automatic t_tie();
    wr_lvl(2, 17); wr_lvl(4, 17); wr_lvl(7, 17);
    irq_req = 8'b1001_0100; ilm_in = 31;
    step();
    check("R6 tie lowest number", take, 1);
    check("R6 tie num", take_num, 2);
    drain();
  endtask

  task automatic t_hold();
    int n, early;
    irq_req = 8'b0000_0100; ilm_in = 31;
    step();
    check("R9 first take", take, 1);
    n = 0; early = 0;
    do begin
      step(); n++;
    end while (!take && n < 40);
    check("R9 retake spacing", n, 20);
    drain();
  endtask

  task automatic t_return();
    int n, m;
    irq_req = 8'b0000_0100; ilm_in = 31; reti_go = 1;
    step();
    reti_go = 0;
    check("R10 return beats take", take, 0);
    check("R10 busy starts", busy, 1);
    n = 0; m = 0;
    while (!take && n < 40) begin
      if (busy) m++;
      step(); n++;
    end
    check("R10 return window", m, 9);
    check("R10 take after return", n, 10);
    drain();
  endtask

  task automatic t_ret_ignored();
    int n;
    irq_req = 8'b0000_0100; ilm_in = 31; sp_aligned4 = 1;
    step();
    irq_req = '0;
    step(); step();
    reti_go = 1;
    step();
    reti_go = 0;
    count_busy(n);
    check("R11 window unchanged", n + 3, 19);
    step();
  endtask

  task automatic t_lvl_write();
    irq_req = 8'b0000_0001; ilm_in = 31;
    lvl_we = 1; lvl_widx = 0; lvl_wdata = 16;
    step();
    lvl_we = 0;
    check("R12 old level at write edge", take, 0);
    step();
    check("R12 new level used", take, 1);
    check("R12 num", take_num, 0);
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_level31();
    t_strict();
    t_enable();
    t_prio();
    t_tie();
    t_hold();
    t_return();
    t_ret_ignored();
    t_lvl_write();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule